// File: doc/BRIEF.md
# Host Interrupt Request Pin Controller

This block lets an embedded controller drive a small set of host interrupt request lines, four by default. For each channel it picks a source level, which is either a hardware event flag or a level bit written by firmware. It can invert that level. It then turns the result into a pin model made of an output value and an output enable.

The pins share one buffer type. In push-pull mode the pin is always driven, high or low. In open-drain mode the pin only ever pulls low and floats otherwise; an external pull-up is assumed. Two overrides sit above that logic. A cleared per-channel enable floats its pin. A low host-power-present input floats every pin and forces every output value low, whatever the other settings are.

Firmware sets all control bits through a small register port with three registers. Reading the level register returns the live line levels rather than the bits that were written.

Top module: `hirq_pin_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every channel has output enable 0 and output value 0. Registers MODE (address 0) and ENA (address 1) read back as zero.
- R2: A channel is in hardware-source mode when MODE bit c is 0. If that channel is enabled (ENA bit c = 1), in push-pull mode (ENA bit 7 = 0), not inverted (MODE bit 4+c = 0), and host power is present, it drives output enable 1 and output value equal to its hardware event input.
- R3: When MODE bit c is 1, channel c takes its level from firmware level bit c, which is written through LVL (address 2) bits [3:0]. The hardware event of that channel then has no effect on its pin.
- R4: When MODE bit 4+c is 1, the selected level of channel c is inverted before it reaches the buffer.
- R5: With ENA bit 7 = 1 (open drain), an enabled and powered channel drives output value 0. Its output enable is 1 when its line level is low and 0 when the line level is high.
- R6: When ENA bit c is 0, channel c has output enable 0 and output value 0, whatever its source, polarity and buffer type are.
- R7: When host_pwr_ok is low, every channel has output enable 0 and output value 0, whatever the register contents and event inputs are. This override ranks above the channel enable and the buffer logic.
- R8: Reading LVL returns the current line level of each channel (source select, then polarity) in bits [3:0], and zero in bits [7:4]. Reading address 3 returns zero.
- R9: MODE reads back exactly as written. ENA reads back bits [3:0] and bit 7 as written, with bits [6:4] reading zero. A write changes only the register it addresses, and a write to address 3 changes nothing.
- R10: A register write takes effect on the pins from the clock edge that captures it. The pin path from the event inputs and host_pwr_ok to the pins has no clock stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_pwr_ok | input | 1 | High while host power is present |
| hw_event | input | NUM_CH | Hardware interrupt event per channel, already gated by its own enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 MODE, 1 ENA, 2 LVL, 3 reserved) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr, combinational |
| irq_val | output | NUM_CH | Pin output value per channel |
| irq_oe | output | NUM_CH | Pin output enable per channel |

## Verification
The bench builds the block with its defaults, NUM_CH = 4 and REG_W = 8. With these values every per-channel bit in MODE, ENA and LVL is live, and the polarity field fills the upper half of MODE exactly. Random writes mix all four channels across every combination of source, polarity, enable, buffer type and host power, so each step of the override order is exercised against the others in the same vector. Directed cases cover reset, a host power drop while everything is enabled, the open-drain float and pull, and writes to the reserved address.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_ENA  = 2'd1,
    ADDR_LVL  = 2'd2,
    ADDR_RSVD = 2'd3
  } hirq_addr_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_t;

  // Selected source level with optional inversion.
  function automatic logic line_level(logic use_fw, logic fw_bit, logic hw_bit, logic inv);
    logic sel;
    sel = use_fw ? fw_bit : hw_bit;
    return sel ^ inv;
  endfunction

  // Override cascade: power, then channel enable, then buffer type.
  function automatic pin_t drive_pin(logic pwr_ok, logic enable, logic open_drain, logic lvl);
    pin_t p;
    if (!pwr_ok) begin
      p.oe  = 1'b0;
      p.val = 1'b0;
    end else if (!enable) begin
      p.oe  = 1'b0;
      p.val = 1'b0;
    end else if (open_drain) begin
      p.oe  = ~lvl;
      p.val = 1'b0;
    end else begin
      p.oe  = 1'b1;
      p.val = lvl;
    end
    return p;
  endfunction

endpackage

// File: rtl/hirq_regs.sv
module hirq_regs
  import hirq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] line_lvl,
  output logic [NUM_CH-1:0] use_fw,
  output logic [NUM_CH-1:0] inv,
  output logic [NUM_CH-1:0] enable,
  output logic [NUM_CH-1:0] fw_lvl,
  output logic              open_drain
);

  localparam int INV_LSB = REG_W / 2;
  localparam int OD_BIT  = REG_W - 1;

  logic [NUM_CH-1:0] mode_q, inv_q, en_q, fw_q;
  logic              od_q;

  logic wr_mode, wr_ena, wr_lvl;
  assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);
  assign wr_ena  = reg_wr && (reg_addr == ADDR_ENA);
  assign wr_lvl  = reg_wr && (reg_addr == ADDR_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      inv_q  <= '0;
      en_q   <= '0;
      fw_q   <= '0;
      od_q   <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode_q <= reg_wdata[NUM_CH-1:0];
        inv_q  <= reg_wdata[INV_LSB +: NUM_CH];
      end
      if (wr_ena) begin
        en_q <= reg_wdata[NUM_CH-1:0];
        od_q <= reg_wdata[OD_BIT];
      end
      if (wr_lvl) begin
        fw_q <= reg_wdata[NUM_CH-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_MODE: begin
        reg_rdata[NUM_CH-1:0]         = mode_q;
        reg_rdata[INV_LSB +: NUM_CH]  = inv_q;
      end
      ADDR_ENA: begin
        reg_rdata[NUM_CH-1:0] = en_q;
        reg_rdata[OD_BIT]     = od_q;
      end
      ADDR_LVL: reg_rdata[NUM_CH-1:0] = line_lvl;
      default:  reg_rdata = '0;
    endcase
  end

  assign use_fw     = mode_q;
  assign inv        = inv_q;
  assign enable     = en_q;
  assign fw_lvl     = fw_q;
  assign open_drain = od_q;

  // R9: an ENA write lands in the enable bits on the next cycle
  p_ena_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> (enable == $past(reg_wdata[NUM_CH-1:0])))
    else $error("p_ena_write_lands_r9");

  // R9: MODE holds its value when not addressed
  p_mode_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(use_fw) && $stable(inv))
    else $error("p_mode_holds_r9");

  // R8: the reserved address always reads zero
  p_rsvd_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_RSVD) |-> (reg_rdata == '0))
    else $error("p_rsvd_reads_zero_r8");

endmodule

// File: rtl/hirq_chan.sv
module hirq_chan
  import hirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic enable,
  input  logic open_drain,
  input  logic use_fw,
  input  logic fw_bit,
  input  logic hw_bit,
  input  logic inv,
  output logic line_lvl,
  output logic pin_val,
  output logic pin_oe
);

  pin_t pin;

  assign line_lvl = line_level(use_fw, fw_bit, hw_bit, inv);
  assign pin      = drive_pin(pwr_ok, enable, open_drain, line_lvl);
  assign pin_val  = pin.val;
  assign pin_oe   = pin.oe;

  // R7: no host power means floating and low
  p_unpowered_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (!pin_oe && !pin_val))
    else $error("p_unpowered_quiet_r7");

  // R6: a disabled channel never drives
  p_disabled_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!pin_oe && !pin_val))
    else $error("p_disabled_float_r6");

  // R5: open drain never drives a high level
  p_od_pulls_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_drain && pin_oe) |-> !pin_val)
    else $error("p_od_pulls_low_only_r5");

  // R2: powered, enabled push-pull always drives the line level
  p_pushpull_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && enable && !open_drain) |-> (pin_oe && (pin_val == line_lvl)))
    else $error("p_pushpull_drives_r2");

endmodule

// File: rtl/hirq_pin_ctrl.sv
module hirq_pin_ctrl
  import hirq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_pwr_ok,
  input  logic [NUM_CH-1:0] hw_event,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] irq_val,
  output logic [NUM_CH-1:0] irq_oe
);

  logic [NUM_CH-1:0] use_fw, inv, enable, fw_lvl, line_lvl;
  logic              open_drain;

  hirq_regs #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .line_lvl   (line_lvl),
    .use_fw     (use_fw),
    .inv        (inv),
    .enable     (enable),
    .fw_lvl     (fw_lvl),
    .open_drain (open_drain)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hirq_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_ok     (host_pwr_ok),
      .enable     (enable[c]),
      .open_drain (open_drain),
      .use_fw     (use_fw[c]),
      .fw_bit     (fw_lvl[c]),
      .hw_bit     (hw_event[c]),
      .inv        (inv[c]),
      .line_lvl   (line_lvl[c]),
      .pin_val    (irq_val[c]),
      .pin_oe     (irq_oe[c])
    );
  end

  // R1: reset leaves every pin floating and low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_oe == '0) && (irq_val == '0))
    else $error("p_reset_quiet_r1");

endmodule

// File: tb/hirq_pin_ctrl_bench.sv
module hirq_pin_ctrl_bench;

  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_pwr_ok = 1'b1;
  logic [N-1:0] hw_event = '0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [N-1:0] irq_val, irq_oe;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // shadow of the programmed state
  logic [N-1:0] s_mode = '0, s_inv = '0, s_en = '0, s_fw = '0;
  logic         s_od = 1'b0;

  always #5 clk = ~clk;

  hirq_pin_ctrl #(.NUM_CH(N), .REG_W(W)) u_hirq_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .host_pwr_ok(host_pwr_ok), .hw_event(hw_event),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_val(irq_val), .irq_oe(irq_oe)
  );

  function automatic logic exp_lvl(int c);
    logic s;
    s = s_mode[c] ? s_fw[c] : hw_event[c];
    return s ^ s_inv[c];
  endfunction

  function automatic logic [1:0] exp_pin(int c); // {oe, val}
    if (!host_pwr_ok) return 2'b00;
    if (!s_en[c]) return 2'b00;
    if (s_od) return {~exp_lvl(c), 1'b0};
    return {1'b1, exp_lvl(c)};
  endfunction

  function automatic string tag_of(int c);
    if (!host_pwr_ok) return "R7";
    if (!s_en[c]) return "R6";
    if (s_od) return "R5";
    if (s_inv[c]) return "R4";
    if (s_mode[c]) return "R3";
    return "R2";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_pins();
    for (int c = 0; c < N; c++) begin
      logic [1:0] e;
      e = exp_pin(c);
      check(tag_of(c), {6'd0, irq_oe[c], irq_val[c]}, {6'd0, e});
    end
  endtask

  task automatic check_read(string req, logic [1:0] a, logic [W-1:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [W-1:0] exp_lvl_read();
    logic [W-1:0] r;
    r = '0;
    for (int c = 0; c < N; c++) r[c] = exp_lvl(c);
    return r;
  endfunction

  // caller is 2ns past a rising edge; returns 2ns past the capturing edge
  task automatic wr_reg(logic [1:0] a, logic [W-1:0] d);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(posedge clk);
    #2;
    reg_wr = 1'b0;
    case (a)
      2'd0: begin s_mode = d[N-1:0]; s_inv = d[4 +: N]; end
      2'd1: begin s_en = d[N-1:0]; s_od = d[7]; end
      2'd2: s_fw = d[N-1:0];
      default: ;
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    hw_event = 4'b1111;
    repeat (3) @(posedge clk);
    #2;
    // R1: quiet during reset
    check("R1", {6'd0, irq_oe[0], irq_val[0]}, '0);
    check("R1", {irq_oe, irq_val}, '0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", {irq_oe, irq_val}, '0);
    check_read("R1", 2'd0, '0);
    check_read("R1", 2'd1, '0);

    // R10/R2: enable push-pull hw source, effect right after the edge
    wr_reg(2'd1, 8'h0F);
    #1;
    check("R10", {4'd0, irq_oe}, 8'h0F);
    hw_event = 4'b0101; #1;
    check("R2", {4'd0, irq_val}, 8'h05);
    check_pins();

    // R3: firmware source ignores hw event
    wr_reg(2'd2, 8'h09);
    wr_reg(2'd0, 8'h0F);
    hw_event = 4'b0110; #1;
    check("R3", {4'd0, irq_val}, 8'h09);

    // R4: invert all
    wr_reg(2'd0, 8'hF0);
    #1;
    check("R4", {4'd0, irq_val}, {4'd0, ~4'b0110});

    // R8: live line level readback
    check_read("R8", 2'd2, 8'h09);
    check_read("R8", 2'd3, 8'h00);

    // R5: open drain, line level = ~hw = 1001
    wr_reg(2'd1, 8'h8F);
    #1;
    check("R5", {irq_oe, irq_val}, {4'b0110, 4'b0000});

    // R7: power drop overrides everything
    host_pwr_ok = 1'b0; #1;
    check("R7", {irq_oe, irq_val}, '0);
    host_pwr_ok = 1'b1; #1;
    check_pins();

    // R6: disable channel 2 only
    wr_reg(2'd1, 8'h0B);
    #1;
    check("R6", {6'd0, irq_oe[2], irq_val[2]}, '0);

    // R9: readback masks, reserved write changes nothing
    check_read("R9", 2'd1, 8'h0B);
    wr_reg(2'd1, 8'hFF);
    check_read("R9", 2'd1, 8'h8F);
    wr_reg(2'd3, 8'hA5);
    check_read("R9", 2'd0, 8'hF0);
    check_read("R9", 2'd1, 8'h8F);
    check_read("R9", 2'd2, exp_lvl_read());

    // random mix
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [W-1:0] d;
      a = 2'($urandom_range(0, 3));
      d = W'($urandom);
      wr_reg(a, d);
      hw_event = N'($urandom);
      host_pwr_ok = ($urandom_range(0, 7) != 0);
      #1;
      check_pins();
      check_read("R8", 2'd2, exp_lvl_read());
      check_read("R9", 2'd0, {s_inv, s_mode});
      check_read("R9", 2'd1, {s_od, 3'd0, s_en});
      check_read("R8", 2'd3, '0);
    end
    finish_run();
  end

endmodule